// File: doc/BRIEF.md
# Supervisory Reset Delay Generator

This block produces the active-low reset line that a microcontroller sees from its supply supervisor. It watches three fault sources: an undervoltage flag on the regulated output (already hysteretic), a flag that the input supply is too low, and a fault request from a window watchdog. While any of them is active, reset is held low. Once the last one goes away, reset stays low for a release delay and then goes high. A one-cycle strobe marks that rising edge so that a downstream watchdog can open its first window.

The delay is counted in ticks of an internal prescaler that divides the clock by `CPT`. A two-bit mode input, shared with the watchdog, selects the delay. Both bits low select the short delay. Every other value selects the long delay. The mode is read only when a delay begins. An undervoltage flag must last for `REACT_T` ticks before it counts as a fault, so short dips on the output rail do not cause a reset. The other two sources act on the next clock edge.

Top module: `rst_delay_gen`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `rst_n_out` is low. After reset it is released once the delay chosen by `mode` has elapsed. The delay starts with the prescaler at zero, so the release comes exactly `N*CPT` cycles after `rst` falls.
- R2: The delay is `FAST_T` ticks when `mode` equals 2'b00 and `SLOW_T` ticks for 2'b01, 2'b10 and 2'b11. From the clock edge that first sees all faults clear, the release comes within one tick of N ticks.
- R3: `vin_low` high forces `rst_n_out` low on the next clock edge.
- R4: `wdg_fault` high forces `rst_n_out` low on the next clock edge. After it clears, the full delay runs before release.
- R5: `uv_flag` must stay high for `REACT_T` consecutive ticks before `rst_n_out` falls. A high stretch with fewer ticks leaves `rst_n_out` high.
- R6: `rst_n_out` stays low and `rst_released` stays low for as long as any fault source is active.
- R7: A fault that arrives while the delay is running stops the delay. When that fault clears, a full delay runs again from zero.
- R8: A change of `mode` while a delay is running has no effect on that delay. It applies to the next delay that starts.
- R9: `rst_released` is high for exactly one cycle: the cycle in which `rst_n_out` first goes high. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| uv_flag | input | 1 | Regulated output below threshold (hysteretic, synchronous) |
| vin_low | input | 1 | Input supply below its operating limit |
| wdg_fault | input | 1 | Fault request from the window watchdog |
| mode | input | 2 | Timing mode; 2'b00 selects the short delay |
| rst_n_out | output | 1 | Reset to the microcontroller, active low |
| rst_released | output | 1 | One-cycle strobe on the rising edge of `rst_n_out` |

## Verification
The assertions assume that all fault inputs are synchronous to `clk`. They also assume that `FAST_T` is no larger than `SLOW_T`, because the minimum-delay check is built on the short delay. The bench drives every input on the falling clock edge and uses a small prescaler and short delays. It sweeps all four mode values against each of the three fault sources. It then holds undervoltage stretches just one tick short of the reaction time and exactly at it, and checks each release against a window of cycles computed from the tick count.

// File: rtl/rst_delay_gen.sv
module rst_delay_gen #(
  parameter int CPT     = 125000,
  parameter int FAST_T  = 16,
  parameter int SLOW_T  = 32,
  parameter int REACT_T = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       uv_flag,
  input  logic       vin_low,
  input  logic       wdg_fault,
  input  logic [1:0] mode,
  output logic       rst_n_out,
  output logic       rst_released
);

  localparam int MAXT = (SLOW_T > FAST_T) ? SLOW_T : FAST_T;
  localparam int PW   = (CPT > 1) ? $clog2(CPT) : 1;
  localparam int DW   = $clog2(MAXT + 1);
  localparam int UW   = $clog2(REACT_T + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CPT - 1);
  localparam logic [UW-1:0] UV_LAST  = UW'(REACT_T);

  typedef enum logic [1:0] {S_HOLD, S_DELAY, S_RUN} state_t;

  state_t         state;
  logic [PW-1:0]  pre_cnt;
  logic [UW-1:0]  uv_cnt;
  logic [DW-1:0]  dly_cnt, dly_len;
  logic           tick, uv_hit, fault_now;
  logic [DW-1:0]  sel_len;

  assign tick      = (pre_cnt == PRE_LAST);
  assign uv_hit    = (uv_cnt == UV_LAST);
  assign fault_now = uv_hit | vin_low | wdg_fault;
  assign sel_len   = (mode == 2'b00) ? DW'(FAST_T) : DW'(SLOW_T);

  always_ff @(posedge clk) begin
    if (rst || tick) pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !uv_flag)     uv_cnt <= '0;
    else if (tick && !uv_hit) uv_cnt <= uv_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_DELAY;
      dly_cnt      <= '0;
      dly_len      <= sel_len;
      rst_n_out    <= 1'b0;
      rst_released <= 1'b0;
    end else begin
      rst_released <= 1'b0;
      if (fault_now) begin
        state     <= S_HOLD;
        dly_cnt   <= '0;
        rst_n_out <= 1'b0;
      end else begin
        case (state)
          S_HOLD: begin
            state   <= S_DELAY;
            dly_cnt <= '0;
            dly_len <= sel_len;
          end
          S_DELAY: begin
            if (tick) begin
              if (dly_cnt == dly_len - DW'(1)) begin
                state        <= S_RUN;
                rst_n_out    <= 1'b1;
                rst_released <= 1'b1;
              end else begin
                dly_cnt <= dly_cnt + 1'b1;
              end
            end
          end
          default: state <= S_RUN;
        endcase
      end
    end
  end

endmodule

module rst_delay_gen_chk #(
  parameter int CPT    = 4,
  parameter int FAST_T = 4
) (
  input logic clk,
  input logic rst,
  input logic vin_low,
  input logic wdg_fault,
  input logic rst_n_out,
  input logic rst_released
);

  localparam logic [31:0] MIN_QUIET = 32'((FAST_T - 1) * CPT);

  logic [31:0] quiet;

  always_ff @(posedge clk) begin
    if (rst || vin_low || wdg_fault) quiet <= '0;
    else if (quiet != 32'hFFFF_FFFF)  quiet <= quiet + 1'b1;
  end

  p_po_low_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rst_n_out);

  p_min_delay_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_out) |-> quiet >= MIN_QUIET);

  p_vin_low_r3: assert property (@(posedge clk) disable iff (rst)
    vin_low |=> !rst_n_out);

  p_wdg_low_r4: assert property (@(posedge clk) disable iff (rst)
    wdg_fault |=> !rst_n_out);

  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (vin_low || wdg_fault) |=> !rst_released);

  p_strobe_edge_r9: assert property (@(posedge clk) disable iff (rst)
    rst_released |-> (rst_n_out && !$past(rst_n_out)));

  p_edge_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_out) |-> rst_released);

endmodule

bind rst_delay_gen rst_delay_gen_chk #(.CPT(CPT), .FAST_T(FAST_T)) u_chk (
  .clk(clk), .rst(rst), .vin_low(vin_low), .wdg_fault(wdg_fault),
  .rst_n_out(rst_n_out), .rst_released(rst_released)
);

// File: tb/rst_delay_gen_test.sv
module rst_delay_gen_test;
  localparam int CPT = 4, FT = 4, ST = 8, RT = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic uv_flag = 1'b0, vin_low = 1'b0, wdg_fault = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rst_n_out, rst_released;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_delay_gen #(.CPT(CPT), .FAST_T(FT), .SLOW_T(ST), .REACT_T(RT)) uut (
    .clk(clk), .rst(rst), .uv_flag(uv_flag), .vin_low(vin_low),
    .wdg_fault(wdg_fault), .mode(mode), .rst_n_out(rst_n_out),
    .rst_released(rst_released));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int dly_of(input logic [1:0] m);
    return (m == 2'b00) ? FT : ST;
  endfunction

  // first high edge must fall in [lo, hi] cycles after the clearing point
  task automatic watch_release(input int n, input int lo, input int hi, input string req);
    int first_hi = 0, strobes = 0, strobe_at = 0;
    for (int m = 1; m <= hi + 3; m++) begin
      cyc(1);
      if (rst_released) begin strobes++; strobe_at = m; end
      if (rst_n_out && first_hi == 0) first_hi = m;
    end
    check(first_hi >= lo && first_hi <= hi, req, first_hi, n);
    check(strobes == 1 && strobe_at == first_hi, "R9 strobe", strobes, 1);
  endtask

  task automatic release_after_clear(input int n, input int off, input string req);
    watch_release(n, (n - 1) * CPT + 2 + off, n * CPT + 1 + off, req);
  endtask

  task automatic uv_assert_wait(output int first_lo);
    first_lo = 0;
    uv_flag = 1'b1;
    for (int m = 1; m <= RT * CPT + 1; m++) begin
      cyc(1);
      if (!rst_n_out && first_lo == 0) first_lo = m;
    end
  endtask

  initial begin
    int lo_at, highs;
    cyc(3);
    check(rst_n_out == 1'b0 && rst_released == 1'b0, "R1 reset state", rst_n_out, 0);
    rst = 1'b0;
    watch_release(FT, FT * CPT, FT * CPT, "R1 power-up release");

    // R2/R3/R4/R5 sweep: every mode against every fault source
    for (int md = 0; md < 4; md++) begin
      for (int src = 0; src < 3; src++) begin
        mode = md[1:0];
        if (src == 0) begin
          vin_low = 1'b1; cyc(1);
          check(rst_n_out == 1'b0, "R3 vin_low asserts", rst_n_out, 0);
          cyc(5);
          check(rst_n_out == 1'b0 && rst_released == 1'b0, "R6 held", rst_n_out, 0);
          vin_low = 1'b0;
          release_after_clear(dly_of(md[1:0]), 0, "R2 delay after vin_low");
        end else if (src == 1) begin
          wdg_fault = 1'b1; cyc(1);
          check(rst_n_out == 1'b0, "R4 wdg asserts", rst_n_out, 0);
          cyc(2);
          wdg_fault = 1'b0;
          release_after_clear(dly_of(md[1:0]), 0, "R4 full delay after wdg");
        end else begin
          uv_assert_wait(lo_at);
          check(lo_at >= (RT - 1) * CPT + 2 && lo_at <= RT * CPT + 1,
                "R5 reaction time", lo_at, RT * CPT);
          cyc(3);
          uv_flag = 1'b0;
          release_after_clear(dly_of(md[1:0]), 1, "R2 delay after uv");
        end
      end
    end

    // R5: stretches one tick short of the reaction time are ignored
    for (int k = 0; k < 3; k++) begin
      highs = 0;
      uv_flag = 1'b1;
      for (int m = 1; m <= (RT - 1) * CPT; m++) begin
        cyc(1);
        if (rst_n_out) highs++;
      end
      uv_flag = 1'b0;
      cyc(2 + k);
      if (rst_n_out) highs++;
      check(highs == (RT - 1) * CPT + 1, "R5 short dip ignored", highs, (RT - 1) * CPT + 1);
    end

    // R7: fault in the middle of the delay restarts it from zero
    mode = 2'b01;
    wdg_fault = 1'b1; cyc(2); wdg_fault = 1'b0;
    cyc((ST - 2) * CPT);
    check(rst_n_out == 1'b0, "R7 still in delay", rst_n_out, 0);
    vin_low = 1'b1; cyc(1); vin_low = 1'b0;
    release_after_clear(ST, 0, "R7 restart full delay");

    // R8: mode switch during the delay leaves the running delay unchanged
    mode = 2'b00;
    wdg_fault = 1'b1; cyc(2); wdg_fault = 1'b0;
    cyc(1); mode = 2'b11;
    watch_release(FT, (FT - 1) * CPT + 1, FT * CPT, "R8 latched fast delay");
    wdg_fault = 1'b1; cyc(2); wdg_fault = 1'b0;
    cyc(1); mode = 2'b00;
    watch_release(ST, (ST - 1) * CPT + 1, ST * CPT, "R8 latched slow delay");

    // R6: both sources overlapping, release only after the later one clears
    mode = 2'b10;
    vin_low = 1'b1; cyc(3); wdg_fault = 1'b1; cyc(2); vin_low = 1'b0;
    cyc(ST * CPT + 4);
    check(rst_n_out == 1'b0, "R6 held while wdg active", rst_n_out, 0);
    wdg_fault = 1'b0;
    release_after_clear(ST, 0, "R6 release after last clear");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule